// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer whose only control path is one 32-bit control word. The word holds a reload count, a run/enable bit and a 7-bit key. While the stored enable bit is set, a new word is taken only if its key is the bitwise inverse of the key already held. Any other write is dropped without a trace. Software therefore has to alternate between a key and its inverse on every service write, which makes it hard for a runaway loop to keep the watchdog fed by accident.

Counting advances on a tick strobe that an external prescaler supplies. When the count runs out for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If the grace count also runs out before an accepted write arrives, the block issues a one-cycle system reset request. The current count and the stored word can be read at all times. The NMI level also serves as the first-stage flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the stored word is 0, the count is 0, the counter is stopped, and both nmi_o and reset_req_o are low.
- R2: While stored bit 8 is 0, a write is accepted whatever its key. The whole 32-bit written value becomes the stored word.
- R3: While stored bit 8 is 1, a write is accepted only if its bits [15:9] equal the inverse of stored bits [15:9]. A rejected write changes neither the stored word, the count nor nmi_o.
- R4: An accepted write loads the count from bits [7:0]. A field value of 0 loads 256.
- R5: After an accepted write with bit 8 set, each tick lowers the count by one. After an accepted write with bit 8 clear, the count holds its loaded value whatever the tick input does.
- R6: On the tick that takes a running count from 1 to expiry with nmi_o low, nmi_o goes high and the count reloads to GRACE (default 10) and keeps running. nmi_o stays high until an accepted write or reset.
- R7: An expiry while nmi_o is high gives reset_req_o high for exactly one cycle. It also stops the counter with a count of 0.
- R8: An accepted write lowers nmi_o and clears the first-stage history. The next expiry then raises nmi_o again instead of requesting reset.
- R9: When a write and a tick arrive in the same cycle, an accepted write wins and the tick is not counted.
- R10: count_o always shows the current count value, one cycle after the edge that changed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| tick | input | 1 | Countdown strobe from the prescaler |
| ctrl_q | output | 32 | Stored control word |
| count_o | output | 9 | Current count |
| nmi_o | output | 1 | Non-maskable interrupt level, also the first-stage flag |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong key comparison shows up on ctrl_q in the cycle right after the write. A lost or extra first-stage flag shows up first at the next expiry: reset_req_o pulses where nmi_o should have risen, or the other way round. A count that is off by one moves the edge of nmi_o by one tick, so the bench compares every output against its model on every clock. The error is then caught in the exact cycle where it first becomes visible.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7,
  parameter int GRACE  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [CNT_W:0]    count_o,
  output logic              nmi_o,
  output logic              reset_req_o
);
  localparam int EN_BIT = CNT_W;
  localparam int KEY_LO = CNT_W + 1;
  localparam int KEY_HI = KEY_LO + KEY_W - 1;
  localparam int CW     = CNT_W + 1;
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE);
  localparam logic [CW-1:0] FULL_V  = CW'(1 << CNT_W);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          hit_q;

  wire key_ok = wr_data[KEY_HI:KEY_LO] == ~ctrl_q[KEY_HI:KEY_LO];
  wire accept = wr_en && (!ctrl_q[EN_BIT] || key_ok);
  wire [CNT_W-1:0] fld = wr_data[CNT_W-1:0];
  wire [CW-1:0] load_v = (fld == '0) ? FULL_V : {1'b0, fld};
  wire step    = !accept && tick && run_q;
  wire expire  = step && cnt_q == CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      run_q       <= 1'b0;
      cnt_q       <= '0;
      hit_q       <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      reset_req_o <= 1'b0;
      if (accept) begin
        ctrl_q <= wr_data;
        cnt_q  <= load_v;
        run_q  <= wr_data[EN_BIT];
        hit_q  <= 1'b0;
      end else if (expire) begin
        if (!hit_q) begin
          hit_q <= 1'b1;
          cnt_q <= GRACE_V;
        end else begin
          reset_req_o <= 1'b1;
          run_q       <= 1'b0;
          cnt_q       <= '0;
        end
      end else if (step) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign count_o = cnt_q;
  assign nmi_o   = hit_q;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W:0]    count_o,
  input logic              nmi_o,
  input logic              reset_req_o
);
  localparam int KEY_LO = CNT_W + 1;
  localparam int KEY_HI = KEY_LO + KEY_W - 1;

  wire bad_key = wr_en && ctrl_q[CNT_W] &&
                 (wr_data[KEY_HI:KEY_LO] != ~ctrl_q[KEY_HI:KEY_LO]);
  wire good_wr = wr_en && !bad_key;

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |=> !reset_req_o);

  assert_req_after_nmi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(nmi_o));

  assert_nmi_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !wr_en) |=> nmi_o);

  assert_reject_keeps_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_key |=> ($stable(ctrl_q) && $stable(nmi_o)));

  assert_accept_clears_nmi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> (!nmi_o && ctrl_q == $past(wr_data)));

  assert_write_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && tick && wr_data[CNT_W-1:0] != '0) |=> count_o == {1'b0, $past(wr_data[CNT_W-1:0])});
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
  .ctrl_q(ctrl_q), .count_o(count_o), .nmi_o(nmi_o), .reset_req_o(reset_req_o));

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic        tick = 0;
  logic [31:0] ctrl_q;
  logic [8:0]  count_o;
  logic        nmi_o, reset_req_o;

  int runs = 0, fails = 0, cycles = 0;

  logic [31:0] m_ctrl;
  int m_cnt, m_run, m_nmi, m_req;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .ctrl_q(ctrl_q), .count_o(count_o), .nmi_o(nmi_o), .reset_req_o(reset_req_o));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_run = 0; m_nmi = 0; m_req = 0;
    end else begin
      m_req = 0;
      if (wr_en && (m_ctrl[8] == 1'b0 || wr_data[15:9] == ~m_ctrl[15:9])) begin
        m_ctrl = wr_data;
        m_cnt  = (wr_data[7:0] == 0) ? 256 : int'(wr_data[7:0]);
        m_run  = int'(wr_data[8]);
        m_nmi  = 0;
      end else if (tick && m_run != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          if (m_nmi == 0) begin m_nmi = 1; m_cnt = 10; end
          else begin m_req = 1; m_run = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2/R3 model word", int'(ctrl_q), int'(m_ctrl));
      chk("R10 model count", int'(count_o), m_cnt);
      chk("R6/R8 model nmi", int'(nmi_o), m_nmi);
      chk("R7 model req", int'(reset_req_o), m_req);
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  task automatic cyc(logic we, logic [31:0] d, logic tk);
    wr_en = we; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 word", int'(ctrl_q), 0);
    chk("R1 count", int'(count_o), 0);
    chk("R1 nmi", int'(nmi_o), 0);
    chk("R1 req", int'(reset_req_o), 0);
    cyc(0, 0, 1);
    chk("R1 stopped", int'(count_o), 0);

    cyc(1, 32'h0000_0B04, 0);
    chk("R2 word", int'(ctrl_q), 32'hB04);
    chk("R4 count", int'(count_o), 4);

    cyc(1, 32'h0000_0B03, 0);
    chk("R3 rejected word", int'(ctrl_q), 32'hB04);
    chk("R3 rejected count", int'(count_o), 4);

    cyc(1, 32'h0000_F503, 0);
    chk("R3 accepted word", int'(ctrl_q), 32'hF503);
    chk("R10 count", int'(count_o), 3);

    for (int i = 0; i < 3; i++) cyc(0, 0, 1);
    chk("R6 nmi", int'(nmi_o), 1);
    chk("R6 grace", int'(count_o), 10);
    for (int i = 0; i < 9; i++) cyc(0, 0, 1);
    chk("R6 nmi held", int'(nmi_o), 1);
    chk("R7 no early req", int'(reset_req_o), 0);
    cyc(0, 0, 1);
    chk("R7 req", int'(reset_req_o), 1);
    cyc(0, 0, 1);
    chk("R7 req single", int'(reset_req_o), 0);
    chk("R7 stopped", int'(count_o), 0);

    cyc(1, 32'h0000_0A00, 0);
    chk("R8 nmi cleared", int'(nmi_o), 0);
    chk("R4 zero is 256", int'(count_o), 256);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1);
    chk("R5 hold", int'(count_o), 256);

    cyc(1, 32'h0000_6702, 0);
    chk("R2 any key", int'(ctrl_q), 32'h6702);
    cyc(0, 0, 1);
    chk("R5 decrement", int'(count_o), 1);
    cyc(1, 32'h0000_9906, 1);
    chk("R9 write wins", int'(count_o), 6);

    for (int i = 0; i < 6; i++) cyc(0, 0, 1);
    chk("R6 nmi again", int'(nmi_o), 1);
    cyc(1, 32'h0000_6701, 0);
    chk("R8 nmi low", int'(nmi_o), 0);
    cyc(0, 0, 1);
    chk("R8 first stage again", int'(nmi_o), 1);
    chk("R8 no req", int'(reset_req_o), 0);

    cyc(1, 32'h0000_6701, 0);
    chk("R3 bad key keeps nmi", int'(nmi_o), 1);
    chk("R3 bad key keeps count", int'(count_o), 10);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule